// File: doc/BRIEF.md
# Routed Local Interrupt Controller

This block gathers 32 interrupt request inputs and forwards each one to a chosen parent interrupt line of a chosen processor core. Every source has its own trigger setting. It can be level-sensitive, active high or active low. It can also be edge-sensitive, on the rising or the falling edge. Every source also has an enable bit. A route byte per source selects the parent lines and cores that it drives. The block drives four parent lines for each of four cores, which gives a 16-bit output vector.

Software programs the block through a flat register space of byte addresses. The route table takes byte-granular writes, one byte per source. Separate write-one ports set and clear the enable mask. A pending status word shows every source that is both asserting and enabled. Software reads that word and services the set bits from the lowest bit upward.

The source inputs are asynchronous. A two-flop synchronizer resamples them before any edge or level is evaluated.

Top module: `rintc_top`

## Requirements
- R1: After reset, the enable, polarity, edge-select, route and status registers all read as zero, and every `irq_out` bit is low.
- R2: The route byte of source s lives in the word at byte address 4*(s/4), in byte lane s%4. A write changes only the lanes whose `reg_be` bit is set. The word reads back as the four route bytes of that word.
- R3: A write of ones to 0x28 sets the matching enable bits, and zero bits in that write leave their enables unchanged. The enable state reads at 0x24. Addresses 0x28 and 0x2C read as zero.
- R4: A write of ones to 0x2C clears the matching enable bits. Writing 0xFFFFFFFF there masks every source.
- R5: Polarity (0x30) and edge-select (0x34) are read/write registers, with one bit per source. A write updates only the byte lanes whose `reg_be` bit is set.
- R6: With its edge bit at 0, a source is pending while its synchronized input equals its polarity bit. Polarity 1 means active high and polarity 0 means active low.
- R7: With its edge bit at 1, a source latches pending on a rising input edge when its polarity bit is 1, and on a falling edge when its polarity bit is 0. The opposite edge does nothing. The latch holds after the input returns, and a write of one to that source's bit at 0x2C clears it.
- R8: The status word at 0x40 reads as pending AND enabled. Writes to 0x40 change no register state.
- R9: `irq_out[4*c+p]` rises one clock after any status source has route bit 4+p set (parent p) and route bit c set (core c). It falls in the same way once no such source remains.
- R10: A source whose route byte has no parent bit or no core bit drives no output. A route byte with several parent and core bits set drives every matching output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in | input | 32 | Asynchronous interrupt source inputs |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_be | input | 4 | Byte-lane enables for writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| irq_out | output | 16 | Parent interrupt lines, index 4*core + parent |

## Verification
The hardest state to reach from the ports is an edge latch that has fired and been cleared while the input is still quiet. A second case is hard for the same reason: an input edge of the wrong direction, which must leave the latch empty. The stimulus first pulses a source that is in edge mode. It then clears and re-enables that source through the disable and enable ports, and shows that nothing comes back. Next it switches the source to the falling edge and drives the rising edge first, then the falling one. Every input change is held for several clocks, so that it travels through the synchronizer, the edge history and the output register before status and outputs are sampled.

// File: rtl/rintc_pkg.sv
package rintc_pkg;

    localparam int SRC_N   = 32;
    localparam int PAR_N   = 4;
    localparam int CORE_N  = 4;
    localparam int ADDR_W  = 8;
    localparam int DATA_W  = 32;
    localparam int ROUTE_W = 8;
    localparam int PAR_LSB = 4;   // parent one-hot field starts here in a route byte

    localparam logic [ADDR_W-1:0] A_ENSTAT = 8'h24;
    localparam logic [ADDR_W-1:0] A_ENSET  = 8'h28;
    localparam logic [ADDR_W-1:0] A_ENCLR  = 8'h2C;
    localparam logic [ADDR_W-1:0] A_POL    = 8'h30;
    localparam logic [ADDR_W-1:0] A_EDGE   = 8'h34;
    localparam logic [ADDR_W-1:0] A_STAT   = 8'h40;

    // Expand byte enables into a bit mask over one data word.
    function automatic logic [DATA_W-1:0] lane_bits(input logic [DATA_W/8-1:0] be);
        logic [DATA_W-1:0] m;
        m = '0;
        for (int i = 0; i < DATA_W/8; i++) begin
            m[i*8 +: 8] = {8{be[i]}};
        end
        return m;
    endfunction

endpackage

// File: rtl/rintc_regs.sv
module rintc_regs
    import rintc_pkg::*;
#(
    parameter int NUM_SRC = SRC_N
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [DATA_W/8-1:0]        be,
    input  logic [DATA_W-1:0]          wdata,
    input  logic [NUM_SRC-1:0]         status,
    output logic [DATA_W-1:0]          rdata,
    output logic [NUM_SRC-1:0]         en,
    output logic [NUM_SRC-1:0]         pol,
    output logic [NUM_SRC-1:0]         trig_edge,
    output logic [NUM_SRC*ROUTE_W-1:0] route,
    output logic [NUM_SRC-1:0]         clr_hit
);

    localparam int LANES = DATA_W / 8;
    localparam int WORDS = NUM_SRC / LANES;
    localparam logic [ADDR_W-1:0] ROUTE_SPAN = ADDR_W'(NUM_SRC);

    typedef struct packed {
        logic [NUM_SRC-1:0]              en;
        logic [NUM_SRC-1:0]              pol;
        logic [NUM_SRC-1:0]              edg;
        logic [NUM_SRC-1:0][ROUTE_W-1:0] rt;
    } regs_t;

    regs_t r_d, r_q;

    logic [DATA_W-1:0]  lane_m;
    logic [NUM_SRC-1:0] lm;
    logic [NUM_SRC-1:0] wset;

    assign lane_m = lane_bits(be);
    assign lm     = lane_m[NUM_SRC-1:0];
    assign wset   = wdata[NUM_SRC-1:0] & lm;

    always_comb begin
        r_d     = r_q;
        clr_hit = '0;
        if (wr_en) begin
            if (addr < ROUTE_SPAN) begin
                for (int w = 0; w < WORDS; w++) begin
                    for (int l = 0; l < LANES; l++) begin
                        if (addr[ADDR_W-1:2] == (ADDR_W-2)'(w) && be[l]) begin
                            r_d.rt[w*LANES+l] = wdata[l*8 +: 8];
                        end
                    end
                end
            end else begin
                case (addr)
                    A_ENSET: r_d.en = r_q.en | wset;
                    A_ENCLR: begin
                        r_d.en  = r_q.en & ~wset;
                        clr_hit = wset;
                    end
                    A_POL:   r_d.pol = (r_q.pol & ~lm) | wset;
                    A_EDGE:  r_d.edg = (r_q.edg & ~lm) | wset;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (addr < ROUTE_SPAN) begin
            for (int w = 0; w < WORDS; w++) begin
                for (int l = 0; l < LANES; l++) begin
                    if (addr[ADDR_W-1:2] == (ADDR_W-2)'(w)) begin
                        rdata[l*8 +: 8] = r_q.rt[w*LANES+l];
                    end
                end
            end
        end else begin
            case (addr)
                A_ENSTAT: rdata = DATA_W'(r_q.en);
                A_POL:    rdata = DATA_W'(r_q.pol);
                A_EDGE:   rdata = DATA_W'(r_q.edg);
                A_STAT:   rdata = DATA_W'(status);
                default:  rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign en        = r_q.en;
    assign pol       = r_q.pol;
    assign trig_edge = r_q.edg;
    assign route     = r_q.rt;

endmodule

// File: rtl/rintc_trig.sv
module rintc_trig #(
    parameter int NUM_SRC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_in,
    input  logic [NUM_SRC-1:0] pol,
    input  logic [NUM_SRC-1:0] trig_edge,
    input  logic [NUM_SRC-1:0] clr_hit,
    output logic [NUM_SRC-1:0] pend
);

    typedef struct packed {
        logic [NUM_SRC-1:0] meta;
        logic [NUM_SRC-1:0] sync;
        logic [NUM_SRC-1:0] prev;
        logic [NUM_SRC-1:0] latch;
    } trig_t;

    trig_t t_d, t_q;

    logic [NUM_SRC-1:0] lvl_act;
    logic [NUM_SRC-1:0] rise;
    logic [NUM_SRC-1:0] fall;
    logic [NUM_SRC-1:0] edge_hit;

    always_comb begin
        lvl_act  = ~(t_q.sync ^ pol);
        rise     = t_q.sync & ~t_q.prev;
        fall     = ~t_q.sync & t_q.prev;
        edge_hit = trig_edge & ((pol & rise) | (~pol & fall));

        t_d       = t_q;
        t_d.meta  = src_in;
        t_d.sync  = t_q.meta;
        t_d.prev  = t_q.sync;
        // a fresh edge wins over a clear in the same cycle
        t_d.latch = (t_q.latch & ~clr_hit) | edge_hit;

        pend = (trig_edge & t_q.latch) | (~trig_edge & lvl_act);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t_q <= '0;
        end else begin
            t_q <= t_d;
        end
    end

endmodule

// File: rtl/rintc_route.sv
module rintc_route
    import rintc_pkg::*;
#(
    parameter int NUM_SRC  = SRC_N,
    parameter int NUM_PAR  = PAR_N,
    parameter int NUM_CORE = CORE_N
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_SRC-1:0]            active,
    input  logic [NUM_SRC*ROUTE_W-1:0]    route,
    output logic [NUM_CORE*NUM_PAR-1:0]   irq
);

    localparam int OUT_N = NUM_CORE * NUM_PAR;

    typedef struct packed {
        logic [OUT_N-1:0] irq;
    } out_t;

    out_t o_d, o_q;
    logic [OUT_N-1:0] hit;

    for (genvar c = 0; c < NUM_CORE; c++) begin : g_core
        for (genvar p = 0; p < NUM_PAR; p++) begin : g_par
            logic [NUM_SRC-1:0] sel;
            for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
                assign sel[s] = route[s*ROUTE_W + PAR_LSB + p] & route[s*ROUTE_W + c];
            end
            assign hit[c*NUM_PAR + p] = |(sel & active);
        end
    end

    always_comb begin
        o_d     = o_q;
        o_d.irq = hit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_q <= '0;
        end else begin
            o_q <= o_d;
        end
    end

    assign irq = o_q.irq;

endmodule

// File: rtl/rintc_top.sv
module rintc_top
    import rintc_pkg::*;
#(
    parameter int NUM_SRC  = SRC_N,
    parameter int NUM_PAR  = PAR_N,
    parameter int NUM_CORE = CORE_N
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_SRC-1:0]          src_in,
    input  logic                        reg_wr,
    input  logic [ADDR_W-1:0]           reg_addr,
    input  logic [DATA_W/8-1:0]         reg_be,
    input  logic [DATA_W-1:0]           reg_wdata,
    output logic [DATA_W-1:0]           reg_rdata,
    output logic [NUM_CORE*NUM_PAR-1:0] irq_out
);

    logic [NUM_SRC-1:0]         en_w;
    logic [NUM_SRC-1:0]         pol_w;
    logic [NUM_SRC-1:0]         edge_w;
    logic [NUM_SRC-1:0]         clr_w;
    logic [NUM_SRC-1:0]         pend_w;
    logic [NUM_SRC-1:0]         status_w;
    logic [NUM_SRC*ROUTE_W-1:0] route_w;

    assign status_w = pend_w & en_w;

    rintc_regs #(.NUM_SRC(NUM_SRC)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr),
        .addr      (reg_addr),
        .be        (reg_be),
        .wdata     (reg_wdata),
        .status    (status_w),
        .rdata     (reg_rdata),
        .en        (en_w),
        .pol       (pol_w),
        .trig_edge (edge_w),
        .route     (route_w),
        .clr_hit   (clr_w)
    );

    rintc_trig #(.NUM_SRC(NUM_SRC)) u_trig (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_in    (src_in),
        .pol       (pol_w),
        .trig_edge (edge_w),
        .clr_hit   (clr_w),
        .pend      (pend_w)
    );

    rintc_route #(
        .NUM_SRC  (NUM_SRC),
        .NUM_PAR  (NUM_PAR),
        .NUM_CORE (NUM_CORE)
    ) u_route (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (status_w),
        .route  (route_w),
        .irq    (irq_out)
    );

endmodule

// File: rtl/rintc_checker.sv
module rintc_checker
    import rintc_pkg::*;
#(
    parameter int NUM_SRC  = SRC_N,
    parameter int NUM_PAR  = PAR_N,
    parameter int NUM_CORE = CORE_N
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        reg_wr,
    input logic [ADDR_W-1:0]           reg_addr,
    input logic [DATA_W/8-1:0]         reg_be,
    input logic [DATA_W-1:0]           reg_wdata,
    input logic [NUM_SRC-1:0]          en,
    input logic [NUM_SRC-1:0]          status,
    input logic [NUM_SRC*ROUTE_W-1:0]  route,
    input logic [NUM_CORE*NUM_PAR-1:0] irq_out
);

    localparam logic [ADDR_W-1:0] ROUTE_SPAN = ADDR_W'(NUM_SRC);

    // R3: ones written to the set port are enabled on the next cycle
    p_set_bits_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_ENSET && reg_be == '1)
        |=> ((en & $past(reg_wdata[NUM_SRC-1:0])) == $past(reg_wdata[NUM_SRC-1:0])));

    // R4: an all-ones write to the clear port masks everything
    p_clear_all_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == A_ENCLR && reg_be == '1 && reg_wdata == '1)
        |=> (en == '0));

    // R2: the route table only moves on a write into its window
    p_route_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && reg_addr < ROUTE_SPAN) |=> $stable(route));

    // R9: an output line is only raised after some source was in status
    p_irq_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_out) |-> $past(|status));

    // R8: with every source masked the outputs are low on the next cycle
    p_masked_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (en == '0) |=> (irq_out == '0));

endmodule

bind rintc_top rintc_checker #(
    .NUM_SRC  (NUM_SRC),
    .NUM_PAR  (NUM_PAR),
    .NUM_CORE (NUM_CORE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_be    (reg_be),
    .reg_wdata (reg_wdata),
    .en        (en_w),
    .status    (status_w),
    .route     (route_w),
    .irq_out   (irq_out)
);

// File: tb/tb_rintc_top.sv
`timescale 1ns/1ps
module tb_rintc_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_in = '0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [3:0]  reg_be = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [15:0] irq_out;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;   // 125 MHz

    rintc_top dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_in    (src_in),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_be    (reg_be),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .irq_out   (irq_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_be = be; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_be = '0; reg_wdata = '0;
    endtask

    task automatic chk_rd(input string req, input logic [7:0] a, input logic [31:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(req, reg_rdata, exp);
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset;
        chk_rd("R1 enable", 8'h24, 32'h0);
        chk_rd("R1 polarity", 8'h30, 32'h0);
        chk_rd("R1 edge", 8'h34, 32'h0);
        chk_rd("R1 status", 8'h40, 32'h0);
        chk_rd("R1 route", 8'h1C, 32'h0);
        chk("R1 irq", 32'(irq_out), 32'h0);
    endtask

    task automatic t_route;
        wr(8'h04, 4'b0101, 32'h11223344);
        chk_rd("R2 lanes", 8'h04, 32'h00220044);
        wr(8'h06, 4'b1000, 32'hAB000000);   // low address bits ignored
        chk_rd("R2 lane3", 8'h04, 32'hAB220044);
        wr(8'h04, 4'b1111, 32'h0);
        chk_rd("R2 cleared", 8'h04, 32'h0);
    endtask

    task automatic t_enable;
        wr(8'h28, 4'hF, 32'h000000F0);
        chk_rd("R3 set", 8'h24, 32'h000000F0);
        wr(8'h28, 4'hF, 32'h0000000F);
        chk_rd("R3 zeros keep", 8'h24, 32'h000000FF);
        chk_rd("R3 set reads 0", 8'h28, 32'h0);
        chk_rd("R3 clr reads 0", 8'h2C, 32'h0);
        wr(8'h2C, 4'hF, 32'h00000030);
        chk_rd("R4 clear", 8'h24, 32'h000000CF);
        wr(8'h2C, 4'hF, 32'hFFFFFFFF);
        chk_rd("R4 all", 8'h24, 32'h0);
    endtask

    task automatic t_cfg;
        wr(8'h30, 4'b0011, 32'hA5A5A5A5);
        chk_rd("R5 pol lanes", 8'h30, 32'h0000A5A5);
        wr(8'h34, 4'b1100, 32'hFFFFFFFF);
        chk_rd("R5 edge lanes", 8'h34, 32'hFFFF0000);
        wr(8'h30, 4'hF, 32'h0);
        wr(8'h34, 4'hF, 32'h0);
        chk_rd("R5 pol back", 8'h30, 32'h0);
    endtask

    task automatic t_level;
        wr(8'h00, 4'b1000, 32'h21000000);   // src3: parent1, core0
        wr(8'h30, 4'hF, 32'h00000008);
        wr(8'h28, 4'hF, 32'h00000008);
        settle(5);
        chk_rd("R6 high idle", 8'h40, 32'h0);
        src_in[3] = 1'b1;
        settle(5);
        chk_rd("R6 high active", 8'h40, 32'h00000008);
        chk("R9 level route", 32'(irq_out), 32'h0002);
        src_in[3] = 1'b0;
        settle(5);
        chk_rd("R6 released", 8'h40, 32'h0);
        chk("R9 drop", 32'(irq_out), 32'h0);
        wr(8'h30, 4'hF, 32'h0);
        settle(5);
        chk_rd("R6 active low", 8'h40, 32'h00000008);
        wr(8'h2C, 4'hF, 32'hFFFFFFFF);
        settle(3);
        chk("R4 outputs quiet", 32'(irq_out), 32'h0);
    endtask

    task automatic t_edge;
        wr(8'h08, 4'b0010, 32'h00008200);   // src9: parent3, core1
        wr(8'h34, 4'hF, 32'h00000200);
        wr(8'h30, 4'hF, 32'h00000200);
        wr(8'h28, 4'hF, 32'h00000200);
        settle(5);
        chk_rd("R7 no edge yet", 8'h40, 32'h0);
        src_in[9] = 1'b1;
        settle(3);
        src_in[9] = 1'b0;
        settle(5);
        chk_rd("R7 rise latched", 8'h40, 32'h00000200);
        chk("R9 edge route", 32'(irq_out), 32'h0080);
        wr(8'h2C, 4'hF, 32'h00000200);
        wr(8'h28, 4'hF, 32'h00000200);
        settle(3);
        chk_rd("R7 latch cleared", 8'h40, 32'h0);
        chk("R7 irq cleared", 32'(irq_out), 32'h0);
        wr(8'h30, 4'hF, 32'h0);
        src_in[9] = 1'b1;
        settle(5);
        chk_rd("R7 wrong edge", 8'h40, 32'h0);
        src_in[9] = 1'b0;
        settle(5);
        chk_rd("R7 fall latched", 8'h40, 32'h00000200);
        chk("R9 fall route", 32'(irq_out), 32'h0080);
        wr(8'h2C, 4'hF, 32'hFFFFFFFF);
        wr(8'h34, 4'hF, 32'h0);
        settle(3);
    endtask

    task automatic t_status;
        wr(8'h28, 4'hF, 32'h00000020);   // src5 active-low, input low
        settle(4);
        chk_rd("R8 masked status", 8'h40, 32'h00000020);
        wr(8'h40, 4'hF, 32'hFFFFFFFF);
        chk_rd("R8 write ignored", 8'h40, 32'h00000020);
        chk_rd("R8 enable intact", 8'h24, 32'h00000020);
        chk_rd("R8 pol intact", 8'h30, 32'h0);
        chk("R10 no route", 32'(irq_out), 32'h0);
        wr(8'h2C, 4'hF, 32'hFFFFFFFF);
    endtask

    task automatic t_multi;
        wr(8'h30, 4'hF, 32'h00001000);
        src_in[12] = 1'b1;
        wr(8'h28, 4'hF, 32'h00001000);
        settle(5);
        chk_rd("R10 status", 8'h40, 32'h00001000);
        chk("R10 zero route", 32'(irq_out), 32'h0);
        wr(8'h0C, 4'b0001, 32'h00000030);   // parents only, no core
        settle(3);
        chk("R10 no core", 32'(irq_out), 32'h0);
        wr(8'h0C, 4'b0001, 32'h00000033);
        settle(3);
        chk("R10 multi", 32'(irq_out), 32'h0033);
        chk_rd("R2 readback", 8'h0C, 32'h00000033);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        settle(2);
        t_reset();
        t_route();
        t_enable();
        t_cfg();
        t_level();
        t_edge();
        t_status();
        t_multi();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule